// File: doc/BRIEF.md
# Multi-Cycle Unsigned Divider with Fixed-Point Option

This block divides an unsigned dividend by an unsigned divisor over a fixed number of clock cycles. The caller presents both operands and a mode bit with a one-cycle start strobe. A fixed number of cycles later the block raises a one-cycle completion pulse and presents a quotient and a remainder. Both stay on the outputs until the next result replaces them.

In integer mode the operands are divided as they are. In fixed-point mode the dividend is first widened and scaled up by a parameterised number of bit positions (16 by default), so the quotient carries that many fraction bits. Only the low word of the quotient is kept. A divisor of zero still runs through the full latency and still produces the completion pulse, but it leaves the quotient and remainder outputs as they were. The datapath is a restoring shift-subtract engine that retires several quotient bits per cycle, so the padded dividend is consumed within the fixed latency.

Top module: `divu_core`

## Requirements
- R1: With mode bit 0, the result is quotient = dividend / divisor and remainder = dividend mod divisor, both unsigned over 32 bits.
- R2: With mode bit 1, the value dividend·2^16 is formed at 48 bits and divided by the divisor. The quotient output holds the low 32 bits of the quotient, and the remainder output holds the modulus.
- R3: With a zero divisor, the quotient and remainder outputs keep their previous values, and the completion pulse still arrives at the normal latency.
- R4: The completion pulse rises in the 18th cycle, counting the cycle in which start is accepted as the first. That is 17 rising edges after the edge that captures start.
- R5: The busy output rises in the cycle after start is accepted, stays high throughout the operation, and is low in the cycle in which the completion pulse is high.
- R6: A start raised while busy is high has no effect. The running operation finishes with its own operands and latency, and no extra completion pulse appears.
- R7: The completion pulse lasts exactly one cycle.
- R8: The quotient and remainder outputs change only in a cycle in which the completion pulse is high, and they hold their values until the next result.
- R9: While rst_n is low, busy, done, quotient and remainder are all zero, and a reset in the middle of an operation abandons it.
- R10: A start in the same cycle as the completion pulse is accepted, which allows operations to run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin a division, taken only when not busy |
| frac_i | input | 1 | Mode: 0 integer, 1 fixed-point (dividend scaled up by 16 bits) |
| dividend_i | input | 32 | Unsigned dividend, sampled with start |
| divisor_i | input | 32 | Unsigned divisor, sampled with start |
| busy_o | output | 1 | High while an operation is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Quotient register |
| remainder_o | output | 32 | Remainder register |

## Verification
The bench builds the block with its defaults: 32-bit operands, a 16-bit fraction shift and an 18-cycle latency. This gives a 48-bit padded dividend that the engine consumes at 3 bits per step over 16 steps. With these values the fixed-point case can produce a quotient wider than 32 bits, which exercises truncation, for example an all-ones dividend over 1. The same build also covers divisors of one and all-ones, dividends below the divisor, zero divisors in both modes, starts issued while busy, back-to-back starts in the completion cycle, and a reset that cuts an operation short.

// File: rtl/divu_pkg.sv
package divu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divu_state_e;

endpackage

// File: rtl/divu_bit.sv
// One restoring shift-subtract cell: brings in one dividend bit, tries the
// subtraction, and keeps the difference only when it does not borrow.
module divu_bit #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] prem_i,
  input  logic          bit_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] prem_o,
  output logic          q_o
);

  logic [DW:0]   shifted;
  logic [DW+1:0] diff;

  always_comb begin
    shifted = {prem_i, bit_i};
    diff    = {1'b0, shifted} - {2'b00, dvs_i};
    q_o     = ~diff[DW+1];
    prem_o  = q_o ? diff[DW-1:0] : shifted[DW-1:0];
  end

endmodule

// File: rtl/divu_step.sv
// Chains BPC restoring cells so that one clock retires BPC quotient bits.
module divu_step #(
  parameter int unsigned DW  = 32,
  parameter int unsigned BPC = 3
) (
  input  logic [DW-1:0]  prem_i,
  input  logic [BPC-1:0] bits_i,
  input  logic [DW-1:0]  dvs_i,
  output logic [DW-1:0]  prem_o,
  output logic [BPC-1:0] qbits_o
);

  logic [BPC:0][DW-1:0] chain;

  assign chain[0] = prem_i;

  generate
    for (genvar g = 0; g < BPC; g++) begin : g_bit
      divu_bit #(.DW(DW)) u_bit (
        .prem_i (chain[g]),
        .bit_i  (bits_i[BPC-1-g]),
        .dvs_i  (dvs_i),
        .prem_o (chain[g+1]),
        .q_o    (qbits_o[BPC-1-g])
      );
    end
  endgenerate

  assign prem_o = chain[BPC];

endmodule

// File: rtl/divu_ctrl.sv
// Sequencer: one load cycle, STEPS iteration cycles, one finishing cycle.
module divu_ctrl
  import divu_pkg::*;
#(
  parameter int unsigned STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic fin_o
);

  localparam int unsigned CW = $clog2(STEPS + 1);

  divu_state_e       state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(STEPS - 1)) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        fin_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/divu_core.sv
module divu_core #(
  parameter int unsigned DW      = 32,
  parameter int unsigned FRAC_SH = 16,
  parameter int unsigned LATENCY = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          frac_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quotient_o,
  output logic [DW-1:0] remainder_o
);

  localparam int unsigned DVD_W = DW + FRAC_SH;
  localparam int unsigned STEPS = LATENCY - 2;
  localparam int unsigned BPC   = (DVD_W + STEPS - 1) / STEPS;
  localparam int unsigned PW    = BPC * STEPS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic load, step, fin, busy;

  divu_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .busy_o  (busy),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin)
  );

  logic [PW-1:0]  sh_q, sh_d;
  logic [DW-1:0]  prem_q, prem_d;
  logic [DW-1:0]  dvs_q;
  logic           dz_q;
  logic [DW-1:0]  quo_q, quo_d;
  logic [DW-1:0]  rem_q, rem_d;
  logic           done_q;
  logic           work_en, res_en;

  logic [DW-1:0]  step_prem;
  logic [BPC-1:0] step_bits;
  logic [PW-1:0]  ext_dvd;

  divu_step #(.DW(DW), .BPC(BPC)) u_step (
    .prem_i  (prem_q),
    .bits_i  (sh_q[PW-1 -: BPC]),
    .dvs_i   (dvs_q),
    .prem_o  (step_prem),
    .qbits_o (step_bits)
  );

  // next-state logic for the working and result registers
  always_comb begin
    ext_dvd = PW'(dividend_i);
    sh_d    = sh_q;
    prem_d  = prem_q;
    work_en = 1'b0;
    quo_d   = quo_q;
    rem_d   = rem_q;
    res_en  = 1'b0;
    if (load) begin
      work_en = 1'b1;
      sh_d    = frac_i ? (ext_dvd << FRAC_SH) : ext_dvd;
      prem_d  = '0;
    end else if (step) begin
      work_en = 1'b1;
      sh_d    = {sh_q[PW-BPC-1:0], step_bits};
      prem_d  = step_prem;
    end
    if (fin && !dz_q) begin
      res_en = 1'b1;
      quo_d  = sh_q[DW-1:0];
      rem_d  = prem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sh_q   <= '0;
      prem_q <= '0;
      dvs_q  <= '0;
      dz_q   <= 1'b0;
    end else if (work_en) begin
      sh_q   <= sh_d;
      prem_q <= prem_d;
      if (load) begin
        dvs_q <= divisor_i;
        dz_q  <= (divisor_i == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (res_en) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
      end
    end
  end

  assign busy_o      = busy;
  assign done_o      = done_q;
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;

endmodule

// File: rtl/divu_chk.sv
module divu_chk #(
  parameter int unsigned DW      = 32,
  parameter int unsigned LATENCY = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] divisor_i,
  input logic [DW-1:0] quotient_o,
  input logic [DW-1:0] remainder_o
);

  localparam int unsigned CW = $clog2(LATENCY + 2);

  logic          armed;
  logic [CW-1:0] since;
  logic          zero_dvs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      since    <= '0;
      zero_dvs <= 1'b0;
    end else if (start_i && !busy_o) begin
      armed    <= 1'b1;
      since    <= CW'(1);
      zero_dvs <= (divisor_i == '0);
    end else if (done_o) begin
      armed <= 1'b0;
    end else if (armed) begin
      since <= since + 1'b1;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (armed && since == CW'(LATENCY))); // R4

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R5

  AST_IDLE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_QUO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quotient_o)); // R8

  AST_REM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(remainder_o)); // R8

  AST_ZERO_DIVISOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zero_dvs) |-> ($stable(quotient_o) && $stable(remainder_o))); // R3

endmodule

bind divu_core divu_chk #(.DW(DW), .LATENCY(LATENCY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .divisor_i   (divisor_i),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o)
);

// File: tb/sim_divu_core.sv
module sim_divu_core;

  localparam int unsigned DW      = 32;
  localparam int unsigned FRAC_SH = 16;
  localparam int unsigned LATENCY = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          frac_i;
  logic [DW-1:0] dividend_i;
  logic [DW-1:0] divisor_i;
  logic          busy_o;
  logic          done_o;
  logic [DW-1:0] quotient_o;
  logic [DW-1:0] remainder_o;

  always #5 clk = ~clk;

  divu_core #(.DW(DW), .FRAC_SH(FRAC_SH), .LATENCY(LATENCY)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .frac_i      (frac_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
  );

  typedef struct {
    logic [DW-1:0] q;
    logic [DW-1:0] r;
    longint        t0;
    string         req;
  } exp_t;

  exp_t          sb[$];
  int            n_chk  = 0;
  int            n_fail = 0;
  int            n_done = 0;
  longint        cyc    = 0;
  logic [DW-1:0] mdl_q  = '0;
  logic [DW-1:0] mdl_r  = '0;
  bit            prev_done = 1'b0;
  bit            finished  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: called at a falling edge; waits for idle, strobes start, pushes expectation
  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input bit frac, input string req);
    longint unsigned num;
    exp_t e;
    while (busy_o) @(negedge clk);
    start_i    = 1'b1;
    frac_i     = frac;
    dividend_i = a;
    divisor_i  = b;
    num = frac ? (64'(a) << FRAC_SH) : 64'(a);
    if (b != '0) begin
      mdl_q = DW'(num / 64'(b));
      mdl_r = DW'(num % 64'(b));
    end
    e.q = mdl_q; e.r = mdl_r; e.t0 = cyc; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R5", "busy after start", 64'(busy_o), 64'd1);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done_o) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every completion pulse
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        n_done++;
        chk(!prev_done, "R7", "done wider than one cycle", 64'(prev_done), 64'd0);
        chk(!busy_o, "R5", "busy low with done", 64'(busy_o), 64'd0);
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "done with nothing pending", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(quotient_o == e.q, e.req, "quotient", 64'(quotient_o), 64'(e.q));
          chk(remainder_o == e.r, e.req, "remainder", 64'(remainder_o), 64'(e.r));
          chk(cyc - e.t0 == longint'(LATENCY), "R4", "latency",
              64'(cyc - e.t0), 64'(LATENCY));
        end
      end
      prev_done = done_o;
    end else begin
      prev_done = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int d0;
    rst_n = 1'b0; start_i = 1'b0; frac_i = 1'b0;
    dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy_o == 1'b0, "R9", "busy in reset", 64'(busy_o), 64'd0);
    chk(done_o == 1'b0, "R9", "done in reset", 64'(done_o), 64'd0);
    chk(quotient_o == '0, "R9", "quotient in reset", 64'(quotient_o), 64'd0);
    chk(remainder_o == '0, "R9", "remainder in reset", 64'(remainder_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: integer division
    drive(32'd100, 32'd7, 1'b0, "R1");
    wait_done();
    repeat (6) @(negedge clk);
    chk(quotient_o == mdl_q, "R8", "quotient held", 64'(quotient_o), 64'(mdl_q));
    chk(remainder_o == mdl_r, "R8", "remainder held", 64'(remainder_o), 64'(mdl_r));
    drive(32'd5, 32'd9, 1'b0, "R1");
    wait_done();
    // R10: each following start lands in the completion cycle
    drive(32'hFFFF_FFFF, 32'd1, 1'b0, "R10");
    wait_done();
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1");
    wait_done();
    drive(32'h8000_0000, 32'd3, 1'b0, "R1");
    wait_done();
    drive(32'd0, 32'd12345, 1'b0, "R1");
    wait_done();

    // R2: fixed-point division
    drive(32'd1, 32'd3, 1'b1, "R2");
    wait_done();
    drive(32'hFFFF_FFFF, 32'd1, 1'b1, "R2");
    wait_done();
    drive(32'h1234_5678, 32'd9, 1'b1, "R2");
    wait_done();
    drive(32'd7, 32'h0001_0000, 1'b1, "R2");
    wait_done();
    drive(32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1, "R2");
    wait_done();

    // R3: zero divisor in both modes keeps the previous results
    drive(32'd77, 32'd0, 1'b0, "R3");
    wait_done();
    drive(32'd77, 32'd0, 1'b1, "R3");
    wait_done();

    // R6: start while busy is ignored
    repeat (3) @(negedge clk);
    drive(32'd1000, 32'd33, 1'b0, "R6");
    repeat (4) @(negedge clk);
    start_i = 1'b1; dividend_i = 32'd999; divisor_i = 32'd2; frac_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    d0 = n_done;
    wait_done();
    repeat (LATENCY + 6) @(negedge clk);
    chk(n_done - d0 == 1, "R6", "completion count", 64'(n_done - d0), 64'd1);
    chk(busy_o == 1'b0, "R6", "idle after ignored start", 64'(busy_o), 64'd0);

    // R9: reset in mid-operation abandons it
    drive(32'd500, 32'd7, 1'b0, "R9");
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    void'(sb.pop_front());
    mdl_q = '0; mdl_r = '0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R9", "busy after mid reset", 64'(busy_o), 64'd0);
    chk(quotient_o == '0, "R9", "quotient after mid reset", 64'(quotient_o), 64'd0);
    rst_n = 1'b1;
    repeat (LATENCY + 6) @(negedge clk);
    chk(sb.size() == 0, "R9", "no stale completion", 64'(sb.size()), 64'd0);
    drive(32'd500, 32'd7, 1'b0, "R1");
    wait_done();
    repeat (3) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule